// File: doc/BRIEF.md
# Cache Write Port Decoder

This block sits on the I/O bus of a small 8-bit processor core and turns processor writes into cache-write transactions for an attached programmable-logic fabric. Three byte-wide address registers, named X, Y and Z, live at consecutive I/O addresses. They are readable and writable, and together they form a 24-bit cache address. X is the least significant byte. Z carries a 4-bit type field in its upper nibble and the top address bits in its lower nibble.

One further I/O address is a data port with no storage behind it. A processor write to that address raises a one-cycle cache write strobe in the same cycle, while the write data and the current 24-bit address are presented to the fabric. The strobe is gated by an interface-enable bit taken from a system control register. A read of the data port changes nothing and returns zero.

Top module: `cache_wr_port_dec`

## Requirements
- R1: While reset is high, and after it, X, Y and Z hold 0, so the cache address output is 0 and reading any address register returns 0.
- R2: A write with io_wr high to I/O address 0x18 (X), 0x19 (Y) or 0x1A (Z) loads io_wdata into that register at the clock edge. A read with io_rd high at the same address then returns the stored byte on io_rdata in the same cycle.
- R3: cache_addr equals {Z, Y, X}, with X in bits 7:0, Y in bits 15:8 and Z in bits 23:16. Z bits 7:4 are the type field and Z bits 3:0 are the top address bits.
- R4: cache_we is high in a cycle exactly when io_wr is high, io_addr is 0x1B and cif_en is 1. It is combinational, so each one-cycle I/O write gives a one-cycle strobe.
- R5: When cif_en is 0, a write to 0x1B produces no strobe and changes no register.
- R6: In any cycle where cache_we is high, cache_data equals io_wdata and cache_addr equals the register contents as of that cycle.
- R7: A read of 0x1B returns 0 on io_rdata, raises no strobe and leaves X, Y and Z unchanged.
- R8: Writes to any address other than 0x18 to 0x1B change no register and raise no strobe.
- R9: An address register write followed by a data-port write in the next cycle gives a strobe carrying the newly written address byte.
- R10: io_rdata is 0 whenever io_rd is low or io_addr is not one of 0x18, 0x19, 0x1A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 6 | Processor I/O address |
| io_wdata | input | 8 | Processor write data |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| cif_en | input | 1 | Cache-interface enable bit from the system control register |
| cache_addr | output | 24 | Cache address {Z, Y, X} |
| cache_data | output | 8 | Cache write data |
| cache_we | output | 1 | Qualified cache write strobe |
| io_rdata | output | 8 | Read data for the address registers |

## Verification
The only state in the block is the three address bytes. A corrupted byte therefore appears on cache_addr in the very next cycle, and it appears on io_rdata as soon as the bench reads that register. The reference model compares cache_addr on every clock, so a bad register load is caught within one cycle of the write. Strobe and data faults are combinational and show up in the same cycle as the offending bus access. This is why the bench sweeps enable, address and read/write combinations, including the cycle that follows each register load.

// File: rtl/cwp_pkg.sv
package cwp_pkg;

    localparam int          CWP_DW        = 8;
    localparam int          CWP_NB        = 3;
    localparam int          CWP_IO_AW     = 6;
    localparam logic [5:0]  CWP_REG_BASE  = 6'h18;
    localparam logic [5:0]  CWP_DATA_ADDR = 6'h1B;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_REG  = 2'd1,
        TGT_DATA = 2'd2
    } cwp_target_e;

endpackage

// File: rtl/cwp_decode.sv
module cwp_decode
    import cwp_pkg::*;
#(
    parameter int               IO_AW     = CWP_IO_AW,
    parameter int               NB        = CWP_NB,
    parameter logic [IO_AW-1:0] REG_BASE  = CWP_REG_BASE,
    parameter logic [IO_AW-1:0] DATA_ADDR = CWP_DATA_ADDR
) (
    input  logic [IO_AW-1:0] io_addr,
    input  logic             io_rd,
    input  logic             io_wr,
    input  logic             cif_en,
    output logic [NB-1:0]    reg_wr,
    output logic [NB-1:0]    reg_rd,
    output logic             cache_we
);

    logic [NB-1:0] hit;
    cwp_target_e   tgt;

    for (genvar g = 0; g < NB; g++) begin : g_hit
        localparam logic [IO_AW-1:0] MY_ADDR = IO_AW'(REG_BASE + g);
        assign hit[g] = (io_addr == MY_ADDR);
    end

    always_comb begin
        if (io_addr == DATA_ADDR)
            tgt = TGT_DATA;
        else if (|hit)
            tgt = TGT_REG;
        else
            tgt = TGT_NONE;
    end

    assign reg_wr   = (io_wr && tgt == TGT_REG) ? hit : '0;
    assign reg_rd   = (io_rd && tgt == TGT_REG) ? hit : '0;
    assign cache_we = io_wr && cif_en && (tgt == TGT_DATA);

endmodule

// File: rtl/cwp_addr_regs.sv
module cwp_addr_regs
    import cwp_pkg::*;
#(
    parameter int DW = CWP_DW,
    parameter int NB = CWP_NB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NB-1:0]    wr_sel,
    input  logic [DW-1:0]    wdata,
    output logic [NB*DW-1:0] regs_flat
);

    for (genvar g = 0; g < NB; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                regs_flat[g*DW +: DW] <= '0;
            else if (wr_sel[g])
                regs_flat[g*DW +: DW] <= wdata;
        end
    end

endmodule

// File: rtl/cwp_rd_mux.sv
module cwp_rd_mux
    import cwp_pkg::*;
#(
    parameter int DW = CWP_DW,
    parameter int NB = CWP_NB
) (
    input  logic [NB-1:0]    rd_sel,
    input  logic [NB*DW-1:0] regs_flat,
    output logic [DW-1:0]    rdata
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NB; i++) begin
            if (rd_sel[i])
                rdata = rdata | regs_flat[i*DW +: DW];
        end
    end

endmodule

// File: rtl/cache_wr_port_dec.sv
module cache_wr_port_dec
    import cwp_pkg::*;
#(
    parameter int               DW        = CWP_DW,
    parameter int               NB        = CWP_NB,
    parameter int               IO_AW     = CWP_IO_AW,
    parameter logic [IO_AW-1:0] REG_BASE  = CWP_REG_BASE,
    parameter logic [IO_AW-1:0] DATA_ADDR = CWP_DATA_ADDR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [DW-1:0]    io_wdata,
    input  logic             io_rd,
    input  logic             io_wr,
    input  logic             cif_en,
    output logic [NB*DW-1:0] cache_addr,
    output logic [DW-1:0]    cache_data,
    output logic             cache_we,
    output logic [DW-1:0]    io_rdata
);

    logic [NB-1:0] reg_wr;
    logic [NB-1:0] reg_rd;

    cwp_decode #(
        .IO_AW(IO_AW), .NB(NB), .REG_BASE(REG_BASE), .DATA_ADDR(DATA_ADDR)
    ) u_dec (
        .io_addr (io_addr),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .cif_en  (cif_en),
        .reg_wr  (reg_wr),
        .reg_rd  (reg_rd),
        .cache_we(cache_we)
    );

    cwp_addr_regs #(.DW(DW), .NB(NB)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_sel   (reg_wr),
        .wdata    (io_wdata),
        .regs_flat(cache_addr)
    );

    cwp_rd_mux #(.DW(DW), .NB(NB)) u_rmux (
        .rd_sel   (reg_rd),
        .regs_flat(cache_addr),
        .rdata    (io_rdata)
    );

    assign cache_data = io_wdata;

endmodule

// File: rtl/cwp_checker.sv
module cwp_checker #(
    parameter int               DW        = 8,
    parameter int               NB        = 3,
    parameter int               IO_AW     = 6,
    parameter logic [IO_AW-1:0] REG_BASE  = 6'h18,
    parameter logic [IO_AW-1:0] DATA_ADDR = 6'h1B
) (
    input logic             clk,
    input logic             rst,
    input logic [IO_AW-1:0] io_addr,
    input logic [DW-1:0]    io_wdata,
    input logic             io_rd,
    input logic             io_wr,
    input logic             cif_en,
    input logic [NB*DW-1:0] cache_addr,
    input logic             cache_we,
    input logic [DW-1:0]    io_rdata
);

    localparam logic [IO_AW-1:0] REG_LAST = IO_AW'(REG_BASE + NB - 1);

    logic reg_hit;
    assign reg_hit = (io_addr >= REG_BASE) && (io_addr <= REG_LAST);

    // R1: reset clears the address registers
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (cache_addr == '0));

    // R4: strobe only for an enabled write to the data port
    a_r4_strobe_qual: assert property (@(posedge clk) disable iff (rst)
        cache_we |-> (io_wr && cif_en && io_addr == DATA_ADDR));

    // R5: disabled interface never strobes
    a_r5_no_strobe_dis: assert property (@(posedge clk) disable iff (rst)
        !cif_en |-> !cache_we);

    // R7: data port reads back as zero
    a_r7_data_rd_zero: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == DATA_ADDR) |-> (io_rdata == '0));

    // R8: no register write means the address holds
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && reg_hit) |=> $stable(cache_addr));

    // R2: each register loads the written byte
    for (genvar g = 0; g < NB; g++) begin : g_ld
        localparam logic [IO_AW-1:0] MY_ADDR = IO_AW'(REG_BASE + g);
        a_r2_reg_load: assert property (@(posedge clk) disable iff (rst)
            (io_wr && io_addr == MY_ADDR) |=> (cache_addr[g*DW +: DW] == $past(io_wdata)));
    end

endmodule

bind cache_wr_port_dec cwp_checker #(
    .DW(DW), .NB(NB), .IO_AW(IO_AW), .REG_BASE(REG_BASE), .DATA_ADDR(DATA_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .cif_en(cif_en),
    .cache_addr(cache_addr), .cache_we(cache_we), .io_rdata(io_rdata)
);

// File: tb/cache_wr_port_dec_tb_top.sv
`timescale 1ns/1ps
module cache_wr_port_dec_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  io_addr;
    logic [7:0]  io_wdata;
    logic        io_rd, io_wr, cif_en;
    logic [23:0] cache_addr;
    logic [7:0]  cache_data;
    logic        cache_we;
    logic [7:0]  io_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    logic [7:0] m_reg [3];

    always #2.5 clk = ~clk;

    cache_wr_port_dec dut_i (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rd(io_rd), .io_wr(io_wr), .cif_en(cif_en),
        .cache_addr(cache_addr), .cache_data(cache_data),
        .cache_we(cache_we), .io_rdata(io_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // drive one bus cycle, compare all outputs before the edge, update model at the edge
    task automatic cyc(input logic r, input logic [5:0] a, input logic [7:0] d,
                       input logic rd, input logic wr, input logic en);
        logic       exp_we;
        logic [7:0] exp_rd;
        bit         is_reg;
        @(negedge clk);
        rst = r; io_addr = a; io_wdata = d; io_rd = rd; io_wr = wr; cif_en = en;
        #1;
        is_reg = (a >= 6'h18) && (a <= 6'h1A);
        exp_we = !r && wr && en && (a == 6'h1B);
        exp_rd = (rd && is_reg) ? m_reg[a - 6'h18] : 8'h00;
        chk(r ? "R1 addr" : "R3 addr", cache_addr, {m_reg[2], m_reg[1], m_reg[0]});
        if (!r) begin
            if (a == 6'h1B && !en) chk("R5 strobe", cache_we, 0);
            else if (a == 6'h1B)   chk("R4 strobe", cache_we, exp_we);
            else                   chk("R8 strobe", cache_we, 0);
            if (exp_we) chk("R6 data", cache_data, d);
            if (rd && is_reg)          chk("R2 rdata", io_rdata, exp_rd);
            else if (rd && a == 6'h1B) chk("R7 rdata", io_rdata, 0);
            else                       chk("R10 rdata", io_rdata, 0);
        end
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 3; i++) m_reg[i] = 8'h00;
        end else if (wr && is_reg) begin
            m_reg[a - 6'h18] = d;
        end
    endtask

    initial begin
        for (int i = 0; i < 3; i++) m_reg[i] = 8'h00;
        rst = 1; io_addr = 0; io_wdata = 0; io_rd = 0; io_wr = 0; cif_en = 0;
        @(posedge clk);
        // R1: reset state, including a read during reset
        cyc(1, 6'h18, 8'h00, 1, 0, 0);
        cyc(1, 6'h00, 8'h00, 0, 0, 0);
        cyc(0, 6'h18, 8'h00, 1, 0, 0);
        // R2, R3: load X, Y, Z and read back
        cyc(0, 6'h18, 8'h34, 0, 1, 1);
        cyc(0, 6'h19, 8'h12, 0, 1, 1);
        cyc(0, 6'h1A, 8'hA5, 0, 1, 1);
        for (int i = 0; i < 3; i++) cyc(0, 6'(6'h18 + i), 8'h00, 1, 0, 1);
        // R4, R6: enabled data-port write
        cyc(0, 6'h1B, 8'h5C, 0, 1, 1);
        // R5: disabled data-port write
        cyc(0, 6'h1B, 8'hC3, 0, 1, 0);
        // R7: data-port read
        cyc(0, 6'h1B, 8'hFF, 1, 0, 1);
        cyc(0, 6'h18, 8'h00, 1, 0, 1);
        // R8: writes to unrelated addresses
        cyc(0, 6'h17, 8'hEE, 0, 1, 1);
        cyc(0, 6'h1C, 8'hDD, 0, 1, 1);
        cyc(0, 6'h3B, 8'hBB, 0, 1, 1);
        // R9: register write then data write in the next cycle
        cyc(0, 6'h18, 8'h77, 0, 1, 1);
        cyc(0, 6'h1B, 8'h99, 0, 1, 1);
        cyc(0, 6'h1A, 8'h3F, 0, 1, 1);
        cyc(0, 6'h1B, 8'h01, 0, 1, 1);
        // R10: read strobe low and unmapped read
        cyc(0, 6'h19, 8'h00, 0, 0, 1);
        cyc(0, 6'h20, 8'h00, 1, 0, 1);
        // mixed pseudo-random traffic
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int n = 0; n < 400; n++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                cyc(0, 6'(6'h16 + lfsr[2:0]), lfsr[15:8], lfsr[3], lfsr[4] & ~lfsr[3], lfsr[5] | lfsr[6]);
            end
        end
        // R1: reset again after state was loaded
        cyc(1, 6'h00, 8'h00, 0, 0, 0);
        cyc(0, 6'h1A, 8'h00, 1, 0, 1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule